// File: doc/BRIEF.md
# Transmitter Delay Compensation Unit

This block supports the fast data phase of a bus controller, where the round trip from the transmit pin through the transceiver and back to the receive pin can last longer than one bit. It measures that loop delay in controller clock cycles. It then checks each transmitted bit at a secondary sample point (SSP). The SSP sits a fixed number of cycles after the start of the bit: the loop delay plus a programmable offset. Setting the offset to the data prescaler times the first data time segment puts the SSP at the same relative place in the echoed bit as the normal sample point.

Bit timing generation sits outside this block. It supplies a one-cycle `bit_start` strobe at the start of every transmitted data-phase bit. The unit samples `tx_bit` on that strobe and places the value in a queue. Several bits can be waiting for their SSP at the same time. Each queued bit is compared with `rx_bit` when its own SSP arrives. A difference raises `bit_err_o` for one cycle, together with `ssp_o`.

The bit streams run in real time and have no valid/ready handshake. The unit cannot push back on its source. A strobe that arrives while the queue is full is dropped. The delay and offset inputs are expected to stay constant while a data phase is active.

Top module: `tdc_unit`

## Requirements
- R1: After reset, `ssp_o` and `bit_err_o` are low and `delay_o` reads 0 in automatic mode.
- R2: `mode` selects the behaviour as follows:
  - 2'b00 disables compensation and `delay_o` reads 0.
  - 2'b01 uses `manual_delay` as the delay and `delay_o` shows it.
  - 2'b10 measures the delay automatically and `delay_o` shows the measured value.
  - 2'b11 behaves like 2'b00.
- R3: In automatic mode the measurement runs once per data phase. If `tx_bit` is first sampled low k rising edges after the edge that saw `data_phase` rise, and `rx_bit` is first sampled low j edges after that tx edge, the measured delay is j (j may be 0).
- R4: A measured delay larger than 63 saturates at 63.
- R5: After a measurement completes, later falling edges within the same data phase do not change it. A new data phase starts a new measurement, and the previous value is held until that measurement finishes.
- R6: If `bit_start` is sampled at edge n with compensation on and `data_phase` high, then with pos = delay + `offset`, `rx_bit` is sampled at edge n+pos+1 and `ssp_o` is high for the one cycle after that edge only.
- R7: At an SSP, `bit_err_o` is 1 exactly when the `tx_bit` value sampled with that bit's `bit_start` differs from the `rx_bit` sampled at the SSP.
- R8: A `bit_start` is ignored, producing no SSP, when compensation is off or when `data_phase` is low.
- R9: Up to DEPTH bits can wait for their SSP in issue order. Strobes arriving while DEPTH bits are pending are dropped.
- R10: `bit_err_o` is never high without `ssp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_phase | input | 1 | High while the fast data phase is active |
| bit_start | input | 1 | One-cycle strobe at the start of each transmitted bit |
| tx_bit | input | 1 | Transmit line as driven to the pin |
| rx_bit | input | 1 | Receive line as seen at the pin |
| mode | input | 2 | Compensation mode (see R2) |
| manual_delay | input | 6 | Delay used in manual mode, in clock cycles |
| offset | input | 7 | SSP offset added to the delay, in clock cycles |
| ssp_o | output | 1 | Secondary sample point strobe |
| bit_err_o | output | 1 | Queued transmit bit differed from the received bit |
| delay_o | output | 6 | Delay in use (measured, manual or 0) |

## Verification
The bound checker watches four properties on every cycle:
- `bit_err_o` is only ever raised together with `ssp_o`.
- An SSP is only ever produced when a queued bit was present.
- The queue never holds more than DEPTH entries.
- The measured delay stays unchanged while the data phase is idle.

Other behaviours need the bench's directed scenarios, because they depend on exact cycle counts and on what was driven earlier:
- the exact SSP cycle for a given delay and offset;
- the measured count, its saturation, and that it is measured only once per phase;
- the mode decode, and that strobes are dropped when compensation is off or the queue is full;
- the in-order comparison of several bits pending at once.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    TDC_OFF    = 2'b00,
    TDC_MANUAL = 2'b01,
    TDC_AUTO   = 2'b10,
    TDC_RSVD   = 2'b11
  } tdc_mode_e;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ARMED,
    MS_COUNT,
    MS_DONE
  } meas_state_e;
endpackage

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas
  import tdc_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             data_phase,
  input  logic             tx_bit,
  input  logic             rx_bit,
  output logic [DLY_W-1:0] meas_o
);
  localparam logic [DLY_W-1:0] MAXV = {DLY_W{1'b1}};

  meas_state_e      state_q;
  logic             dp_q, tx_q, rx_q;
  logic [DLY_W-1:0] cnt_q;
  logic             tx_fall, rx_fall, dp_rise;

  assign tx_fall = tx_q & ~tx_bit;
  assign rx_fall = rx_q & ~rx_bit;
  assign dp_rise = data_phase & ~dp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q    <= 1'b0;
      tx_q    <= 1'b1;
      rx_q    <= 1'b1;
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      meas_o  <= '0;
    end else begin
      dp_q <= data_phase;
      tx_q <= tx_bit;
      rx_q <= rx_bit;
      if (!data_phase || !enable) begin
        state_q <= MS_IDLE;
      end else begin
        case (state_q)
          MS_IDLE: if (dp_rise) state_q <= MS_ARMED;
          MS_ARMED: begin
            if (tx_fall) begin
              if (rx_fall) begin
                meas_o  <= '0;
                state_q <= MS_DONE;
              end else begin
                cnt_q   <= '0;
                state_q <= MS_COUNT;
              end
            end
          end
          MS_COUNT: begin
            if (rx_fall) begin
              meas_o  <= (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;
              state_q <= MS_DONE;
            end else if (cnt_q != MAXV) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= MS_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdc_ssp_queue.sv
module tdc_ssp_queue #(
  parameter int TS_W  = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            push_bit,
  input  logic [TS_W-1:0] pos,
  input  logic            rx_bit,
  output logic            ssp_o,
  output logic            err_o,
  output logic [CW-1:0]   count_o
);
  logic [TS_W-1:0] due_q [DEPTH];
  logic            bit_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [TS_W-1:0] timer_q;
  logic            do_push, pop;

  assign do_push = push && (count_o != CW'(DEPTH));
  assign pop     = (count_o != '0) && (due_q[rd_q] == timer_q);

  always_ff @(posedge clk) begin
    if (do_push) begin
      due_q[wr_q] <= timer_q + pos + 1'b1;
      bit_q[wr_q] <= push_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
      ssp_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      timer_q <= timer_q + 1'b1;
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)     rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
      ssp_o <= pop;
      err_o <= pop & (bit_q[rd_q] ^ rx_bit);
    end
  end
endmodule

// File: rtl/tdc_unit.sv
module tdc_unit
  import tdc_pkg::*;
#(
  parameter int DLY_W = 6,
  parameter int OFS_W = 7,
  parameter int DEPTH = 8,
  localparam int POS_W = ((DLY_W > OFS_W) ? DLY_W : OFS_W) + 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_phase,
  input  logic             bit_start,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic [1:0]       mode,
  input  logic [DLY_W-1:0] manual_delay,
  input  logic [OFS_W-1:0] offset,
  output logic             ssp_o,
  output logic             bit_err_o,
  output logic [DLY_W-1:0] delay_o
);
  tdc_mode_e        mode_e;
  logic             auto_en, comp_on, push;
  logic [DLY_W-1:0] meas;
  logic [POS_W-1:0] pos;
  logic [CW-1:0]    q_count;

  assign mode_e  = tdc_mode_e'(mode);
  assign auto_en = (mode_e == TDC_AUTO);
  assign comp_on = (mode_e == TDC_AUTO) || (mode_e == TDC_MANUAL);
  assign push    = bit_start & data_phase & comp_on;

  always_comb begin
    case (mode_e)
      TDC_AUTO:   delay_o = meas;
      TDC_MANUAL: delay_o = manual_delay;
      default:    delay_o = '0;
    endcase
  end

  assign pos = POS_W'(delay_o) + POS_W'(offset);

  tdc_delay_meas #(.DLY_W(DLY_W)) u_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (auto_en),
    .data_phase (data_phase),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit),
    .meas_o     (meas)
  );

  tdc_ssp_queue #(.TS_W(POS_W), .DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_bit (tx_bit),
    .pos      (pos),
    .rx_bit   (rx_bit),
    .ssp_o    (ssp_o),
    .err_o    (bit_err_o),
    .count_o  (q_count)
  );
endmodule

// File: rtl/tdc_unit_chk.sv
module tdc_unit_chk #(
  parameter int DLY_W = 6,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_phase,
  input logic [1:0]       mode,
  input logic [DLY_W-1:0] delay_o,
  input logic             ssp_o,
  input logic             bit_err_o,
  input logic [CW-1:0]    q_count
);
  // R10
  err_needs_ssp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err_o |-> ssp_o);

  // R9
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  // R6
  ssp_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssp_o |-> ($past(q_count) != '0));

  // R5
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b10 && !data_phase && !$past(data_phase))
      |-> $stable(delay_o));
endmodule

bind tdc_unit tdc_unit_chk #(.DLY_W(DLY_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_phase (data_phase),
  .mode       (mode),
  .delay_o    (delay_o),
  .ssp_o      (ssp_o),
  .bit_err_o  (bit_err_o),
  .q_count    (q_count)
);

// File: tb/tdc_unit_tb.sv
module tdc_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data_phase = 1'b0;
  logic       bit_start = 1'b0;
  logic       tx_bit = 1'b1;
  logic       rx_bit = 1'b1;
  logic [1:0] mode = 2'b10;
  logic [5:0] manual_delay = '0;
  logic [6:0] offset = '0;
  logic       ssp_o, bit_err_o;
  logic [5:0] delay_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tdc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .data_phase(data_phase), .bit_start(bit_start),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .mode(mode), .manual_delay(manual_delay),
    .offset(offset), .ssp_o(ssp_o), .bit_err_o(bit_err_o), .delay_o(delay_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bit issued at edge 0; SSP expected after edge pos+1.
  task automatic run_bit(input logic txv, input logic rxv, input int pos,
                         input logic exp_err, input string req);
    @(negedge clk);
    bit_start = 1'b1; tx_bit = txv; rx_bit = rxv;
    @(posedge clk);
    @(negedge clk);
    bit_start = 1'b0;
    for (int i = 1; i <= pos + 2; i++) begin
      @(posedge clk); #1;
      check(ssp_o == (i == pos + 1), req, ssp_o, (i == pos + 1));
      if (i == pos + 1) check(bit_err_o == exp_err, req, bit_err_o, exp_err);
    end
    @(negedge clk);
    tx_bit = 1'b1; rx_bit = 1'b1;
  endtask

  // New data phase; tx falls, rx falls k edges later.
  task automatic measure(input int k, input int exp, input string req);
    @(negedge clk);
    data_phase = 1'b0; tx_bit = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
    data_phase = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tx_bit = 1'b0;
    if (k == 0) rx_bit = 1'b0;
    else begin
      repeat (k) @(negedge clk);
      rx_bit = 1'b0;
    end
    repeat (2) @(negedge clk);
    check(delay_o == 6'(exp), req, delay_o, exp);
    tx_bit = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ssp_o == 1'b0, "R1", ssp_o, 0);
    check(bit_err_o == 1'b0, "R1", bit_err_o, 0);
    check(delay_o == 6'd0, "R1", delay_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_manual();
    @(negedge clk);
    mode = 2'b01; manual_delay = 6'd5; offset = 7'd3; data_phase = 1'b1;
    #1 check(delay_o == 6'd5, "R2", delay_o, 5);
    run_bit(1'b1, 1'b1, 8, 1'b0, "R6");
    run_bit(1'b1, 1'b0, 8, 1'b1, "R7");
    run_bit(1'b0, 1'b0, 8, 1'b0, "R7");
  endtask

  task automatic t_auto();
    @(negedge clk);
    mode = 2'b10; offset = 7'd31;
    measure(7, 7, "R3");
    run_bit(1'b1, 1'b1, 38, 1'b0, "R6");
    run_bit(1'b0, 1'b1, 38, 1'b1, "R7");
  endtask

  task automatic t_ignore();
    // second edge pair within the same phase
    @(negedge clk); tx_bit = 1'b0;
    repeat (2) @(negedge clk); rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    check(delay_o == 6'd7, "R5", delay_o, 7);
    tx_bit = 1'b1; rx_bit = 1'b1;
    mode = 2'b01; #1 check(delay_o == 6'd5, "R2", delay_o, 5);
    @(negedge clk); mode = 2'b10; #1 check(delay_o == 6'd7, "R2", delay_o, 7);
    measure(3, 3, "R5");
    measure(80, 63, "R4");
    measure(0, 0, "R3");
  endtask

  task automatic t_quiet(input logic [1:0] m, input logic dp, input string req);
    int seen = 0;
    @(negedge clk);
    mode = m; data_phase = dp; manual_delay = 6'd4; offset = 7'd4;
    bit_start = 1'b1;
    @(negedge clk); bit_start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      if (ssp_o) seen++;
    end
    check(seen == 0, req, seen, 0);
    if (m != 2'b01) check(delay_o == 6'd0, "R2", delay_o, 0);
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    mode = 2'b01; manual_delay = 6'd10; offset = 7'd0; data_phase = 1'b1; rx_bit = 1'b1;
    for (int i = 0; i < 24; i++) begin
      bit_start = (i == 0 || i == 4 || i == 8);
      tx_bit = (i == 4) ? 1'b0 : 1'b1;
      @(posedge clk); #1;
      check(ssp_o == (i == 11 || i == 15 || i == 19), "R9", ssp_o,
            (i == 11 || i == 15 || i == 19));
      check(bit_err_o == (i == 15), "R7", bit_err_o, (i == 15));
      @(negedge clk);
    end
    bit_start = 1'b0; tx_bit = 1'b1;
  endtask

  task automatic t_full();
    int seen = 0;
    @(negedge clk);
    mode = 2'b01; manual_delay = 6'd20; offset = 7'd0; data_phase = 1'b1;
    for (int i = 0; i < 10; i++) begin
      bit_start = 1'b1;
      @(negedge clk);
    end
    bit_start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (ssp_o) seen++;
    end
    check(seen == 8, "R9", seen, 8);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_manual();
    t_auto();
    t_ignore();
    t_quiet(2'b00, 1'b1, "R8");
    t_quiet(2'b11, 1'b1, "R8");
    t_quiet(2'b01, 1'b0, "R8");
    t_pipeline();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule